// File: doc/BRIEF.md
# Multi-thread core sleep-state resolver

This block keeps one requested low-power state for each hardware thread of a single core. It folds those states into one core power state that a separate power sequencer acts on. Each thread has four inputs: a request strobe that carries a target state and an entry type, an interrupt line aimed only at that thread, a pulse for a hit on the monitored address, and a pulse for an expired timed-wait deadline. One interrupt line serves the whole package and may wake a sleeping thread. A synchronous active-high reset brings every thread back to the running state.

Each thread register updates on the clock edge that samples its inputs. The core state is registered on the same edge, so `core_state` always matches the `thread_state` shown in the same cycle. A wake event beats a sleep request that arrives in the same cycle. A monitor-hit wake and a deadline wake count only when the thread went to sleep through the matching kind of wait.

Top module: `core_sleep_resolver`

## Requirements
- R1: While `rst` is high at a clock edge, every thread state and the core state become C0 (code 0) after that edge.
- R2: A request (`req_valid[i]` high) with state code 0..5 and entry type 0, 1 or 2, with no wake for that thread, sets `thread_state[i]` to that code one cycle later. The codes are C0=0, C1=1, C1E=2, C6=3, C8=4, C10=5. The entry types are 0 = plain halt, 1 = monitor wait, 2 = timed monitor wait.
- R3: A request with state code 6 or 7, or with entry type 3, is ignored, and the thread keeps its state.
- R4: `irq[i]` returns thread i to C0 on the next cycle and leaves every other thread unchanged.
- R5: `mon_hit[i]` returns thread i to C0 only if its current state was entered with entry type 1 or 2. Otherwise it has no effect.
- R6: `deadline[i]` returns thread i to C0 only if its current state was entered with entry type 2. Otherwise it has no effect.
- R7: `pkg_irq` returns to C0 only the lowest-indexed thread whose state is not C0. If every thread is in C0, it has no effect.
- R8: If a wake event (R4 to R7) and a request reach the same thread in the same cycle, the thread is in C0 on the next cycle.
- R9: `core_state` equals the smallest code among all thread states in the same cycle, so it is C0 whenever any thread is in C0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_THREADS | Per-thread state request strobe |
| req_state | input | 3*NUM_THREADS | Per-thread requested state code, thread i at bits [3i+2:3i] |
| req_kind | input | 2*NUM_THREADS | Per-thread entry type, thread i at bits [2i+1:2i] |
| irq | input | NUM_THREADS | Interrupt directed at one thread |
| mon_hit | input | NUM_THREADS | Monitored-address access pulse per thread |
| deadline | input | NUM_THREADS | Timed-wait deadline expiry pulse per thread |
| pkg_irq | input | 1 | Package-wide interrupt |
| thread_state | output | 3*NUM_THREADS | Current state code of each thread |
| core_state | output | 3 | Resolved core state code |

## Verification
The bench aims at the corners where wake sources could leak between threads or between entry types. A directed interrupt that reached a neighbour would show up as a second thread falling to C0. A monitor hit on a thread that used a plain halt, or a deadline on a thread that used an untimed monitor wait, would wrongly wake a thread that should keep sleeping. The package interrupt is tested with several threads asleep and with none asleep: a wrong priority wakes the wrong thread, and a missing no-sleeper guard changes state when nothing should happen. A request that arrives together with a wake tests the priority rule, because a design that let the request win would leave the thread asleep. Invalid codes test whether the block corrupts the state with a code outside the encoding.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  localparam int STATE_W = 3;
  localparam int KIND_W  = 2;

  typedef enum logic [STATE_W-1:0] {
    CST_C0  = 3'd0,
    CST_C1  = 3'd1,
    CST_C1E = 3'd2,
    CST_C6  = 3'd3,
    CST_C8  = 3'd4,
    CST_C10 = 3'd5
  } cstate_e;

  typedef enum logic [KIND_W-1:0] {
    ENTRY_HALT    = 2'd0,
    ENTRY_MONITOR = 2'd1,
    ENTRY_TIMED   = 2'd2
  } entry_e;

  localparam logic [STATE_W-1:0] DEEPEST = CST_C10;

  function automatic logic code_ok(input logic [STATE_W-1:0] code);
    return code <= DEEPEST;
  endfunction

  function automatic logic kind_ok(input logic [KIND_W-1:0] kind);
    return kind != 2'd3;
  endfunction
endpackage

// File: rtl/thread_tracker.sv
module thread_tracker
  import sleep_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [STATE_W-1:0] req_code,
  input  logic [KIND_W-1:0]  req_kind,
  input  logic               irq,
  input  logic               mon_hit,
  input  logic               deadline,
  input  logic               pkg_grant,
  output logic [STATE_W-1:0] state_q,
  output logic [STATE_W-1:0] state_d
);
  logic mon_armed_q, timed_armed_q;
  logic mon_armed_d, timed_armed_d;
  logic wake, accept;

  always_comb begin
    wake   = irq | pkg_grant | (mon_hit & mon_armed_q) | (deadline & timed_armed_q);
    accept = req_valid & code_ok(req_code) & kind_ok(req_kind);
    state_d       = state_q;
    mon_armed_d   = mon_armed_q;
    timed_armed_d = timed_armed_q;
    if (wake) begin
      state_d       = CST_C0;
      mon_armed_d   = 1'b0;
      timed_armed_d = 1'b0;
    end else if (accept) begin
      state_d       = req_code;
      mon_armed_d   = (req_kind == ENTRY_MONITOR) || (req_kind == ENTRY_TIMED);
      timed_armed_d = (req_kind == ENTRY_TIMED);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= CST_C0;
      mon_armed_q   <= 1'b0;
      timed_armed_q <= 1'b0;
    end else begin
      state_q       <= state_d;
      mon_armed_q   <= mon_armed_d;
      timed_armed_q <= timed_armed_d;
    end
  end
endmodule

// File: rtl/pkg_wake_arbiter.sv
module pkg_wake_arbiter #(
  parameter int NUM_THREADS = 4
) (
  input  logic                   pkg_irq,
  input  logic [NUM_THREADS-1:0] sleeping,
  output logic [NUM_THREADS-1:0] grant
);
  always_comb begin
    grant = '0;
    for (int i = NUM_THREADS - 1; i >= 0; i--) begin
      if (pkg_irq && sleeping[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/state_min_reducer.sv
module state_min_reducer #(
  parameter int NUM_IN = 4,
  parameter int W      = 3
) (
  input  logic [NUM_IN*W-1:0] vals,
  output logic [W-1:0]        min_val
);
  always_comb begin
    min_val = {W{1'b1}};
    for (int i = 0; i < NUM_IN; i++) begin
      if (vals[i*W +: W] < min_val) min_val = vals[i*W +: W];
    end
  end
endmodule

// File: rtl/core_sleep_resolver.sv
module core_sleep_resolver
  import sleep_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_THREADS-1:0]         req_valid,
  input  logic [STATE_W*NUM_THREADS-1:0] req_state,
  input  logic [KIND_W*NUM_THREADS-1:0]  req_kind,
  input  logic [NUM_THREADS-1:0]         irq,
  input  logic [NUM_THREADS-1:0]         mon_hit,
  input  logic [NUM_THREADS-1:0]         deadline,
  input  logic                           pkg_irq,
  output logic [STATE_W*NUM_THREADS-1:0] thread_state,
  output logic [STATE_W-1:0]             core_state
);
  localparam int FLAT_W = STATE_W * NUM_THREADS;

  logic [FLAT_W-1:0]      next_flat;
  logic [NUM_THREADS-1:0] sleeping;
  logic [NUM_THREADS-1:0] grant;
  logic [STATE_W-1:0]     core_d;
  logic [STATE_W-1:0]     core_q;

  pkg_wake_arbiter #(.NUM_THREADS(NUM_THREADS)) u_arb (
    .pkg_irq  (pkg_irq),
    .sleeping (sleeping),
    .grant    (grant)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    thread_tracker u_trk (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid[t]),
      .req_code  (req_state[t*STATE_W +: STATE_W]),
      .req_kind  (req_kind[t*KIND_W +: KIND_W]),
      .irq       (irq[t]),
      .mon_hit   (mon_hit[t]),
      .deadline  (deadline[t]),
      .pkg_grant (grant[t]),
      .state_q   (thread_state[t*STATE_W +: STATE_W]),
      .state_d   (next_flat[t*STATE_W +: STATE_W])
    );
    assign sleeping[t] = thread_state[t*STATE_W +: STATE_W] != CST_C0;
  end

  state_min_reducer #(.NUM_IN(NUM_THREADS), .W(STATE_W)) u_min (
    .vals    (next_flat),
    .min_val (core_d)
  );

  always_ff @(posedge clk) begin
    if (rst) core_q <= CST_C0;
    else     core_q <= core_d;
  end

  assign core_state = core_q;
endmodule

// File: rtl/sleep_resolver_checker.sv
module sleep_resolver_checker #(
  parameter int NUM_THREADS = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_THREADS-1:0]   req_valid,
  input logic [NUM_THREADS-1:0]   irq,
  input logic [NUM_THREADS-1:0]   mon_hit,
  input logic [NUM_THREADS-1:0]   deadline,
  input logic                     pkg_irq,
  input logic [3*NUM_THREADS-1:0] thread_state,
  input logic [2:0]               core_state
);
  logic [NUM_THREADS-1:0] running;
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_run
    assign running[t] = thread_state[t*3 +: 3] == 3'd0;
  end

  assert_reset_core_R1: assert property (@(posedge clk) rst |=> core_state == 3'd0);
  assert_reset_thr_R1: assert property (@(posedge clk) rst |=> running == {NUM_THREADS{1'b1}});
  assert_any_c0_R9: assert property (@(posedge clk) disable iff (rst)
    (|running) |-> core_state == 3'd0);
  assert_pkg_lowest_R7: assert property (@(posedge clk) disable iff (rst)
    (pkg_irq && !running[0]) |=> running[0]);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    assert_core_shallowest_R9: assert property (@(posedge clk) disable iff (rst)
      core_state <= thread_state[t*3 +: 3]);
    assert_code_legal_R3: assert property (@(posedge clk) disable iff (rst)
      thread_state[t*3 +: 3] <= 3'd5);
    assert_irq_wakes_R4: assert property (@(posedge clk) disable iff (rst)
      irq[t] |=> running[t]);
    assert_wake_beats_req_R8: assert property (@(posedge clk) disable iff (rst)
      (irq[t] && req_valid[t]) |=> running[t]);
    assert_quiet_holds_R4: assert property (@(posedge clk) disable iff (rst)
      (!irq[t] && !req_valid[t] && !mon_hit[t] && !deadline[t] && !pkg_irq)
      |=> $stable(thread_state[t*3 +: 3]));
  end
endmodule

bind core_sleep_resolver sleep_resolver_checker #(.NUM_THREADS(NUM_THREADS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .irq          (irq),
  .mon_hit      (mon_hit),
  .deadline     (deadline),
  .pkg_irq      (pkg_irq),
  .thread_state (thread_state),
  .core_state   (core_state)
);

// File: tb/tb_core_sleep_resolver.sv
module tb_core_sleep_resolver;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   req_valid, irq, mon_hit, deadline;
  logic [3*N-1:0] req_state;
  logic [2*N-1:0] req_kind;
  logic           pkg_irq;
  logic [3*N-1:0] thread_state;
  logic [2:0]     core_state;

  int    m_st[N];
  bit    m_fm[N], m_ft[N];
  int    checks = 0, fails = 0;
  string phase  = "R1 reset";
  bit    done   = 0;

  core_sleep_resolver #(.NUM_THREADS(N)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_state(req_state),
    .req_kind(req_kind), .irq(irq), .mon_hit(mon_hit), .deadline(deadline),
    .pkg_irq(pkg_irq), .thread_state(thread_state), .core_state(core_state)
  );

  always #2 clk = ~clk;

  task automatic clr();
    req_valid = '0; req_state = '0; req_kind = '0;
    irq = '0; mon_hit = '0; deadline = '0; pkg_irq = 1'b0;
  endtask

  task automatic req(input int t, input int code, input int kind);
    req_valid[t] = 1'b1;
    req_state[t*3 +: 3] = code[2:0];
    req_kind[t*2 +: 2]  = kind[1:0];
  endtask

  task automatic model();
    int tgt;
    bit wake;
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_st[i] = 0; m_fm[i] = 0; m_ft[i] = 0; end
      return;
    end
    tgt = -1;
    for (int i = 0; i < N; i++) if (m_st[i] != 0 && tgt < 0) tgt = i;
    for (int i = 0; i < N; i++) begin
      wake = irq[i] || (mon_hit[i] && m_fm[i]) || (deadline[i] && m_ft[i]) ||
             (pkg_irq && tgt == i);
      if (wake) begin
        m_st[i] = 0; m_fm[i] = 0; m_ft[i] = 0;
      end else if (req_valid[i] && req_state[i*3 +: 3] <= 5 && req_kind[i*2 +: 2] != 3) begin
        m_st[i] = int'(req_state[i*3 +: 3]);
        m_fm[i] = req_kind[i*2 +: 2] == 1 || req_kind[i*2 +: 2] == 2;
        m_ft[i] = req_kind[i*2 +: 2] == 2;
      end
    end
  endtask

  task automatic compare();
    int mn;
    mn = 7;
    for (int i = 0; i < N; i++) begin
      if (m_st[i] < mn) mn = m_st[i];
      checks++;
      if (int'(thread_state[i*3 +: 3]) != m_st[i]) begin
        fails++;
        $display("FAIL %s thread %0d actual=%0d expected=%0d", phase, i,
                 thread_state[i*3 +: 3], m_st[i]);
      end
    end
    checks++;
    if (int'(core_state) != mn) begin
      fails++;
      $display("FAIL %s / R9 core actual=%0d expected=%0d", phase, core_state, mn);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
    clr();
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clr();
    @(negedge clk);
    phase = "R1 reset";
    tick(); tick();
    rst = 1'b0;
    tick();

    phase = "R2 R9 entry";
    req(0, 1, 0); req(1, 3, 1); req(2, 5, 2); req(3, 2, 0);
    tick(); tick();

    phase = "R3 bad code";
    req(0, 6, 0); req(1, 7, 1); req(2, 1, 3);
    tick();

    phase = "R4 directed irq";
    irq[1] = 1'b1;
    tick();

    phase = "R5 monitor hit";
    req(1, 4, 1);
    tick();
    mon_hit = 4'b1111;
    tick();

    phase = "R6 deadline";
    req(1, 3, 2); req(0, 4, 1); req(3, 5, 0);
    tick();
    deadline = 4'b1111;
    tick();
    phase = "R5 timed also wakes on hit";
    req(2, 5, 2);
    tick();
    mon_hit[2] = 1'b1;
    tick();

    phase = "R7 package irq";
    req(1, 3, 0); req(2, 4, 0);
    tick();
    for (int k = 0; k < 5; k++) begin
      pkg_irq = 1'b1;
      tick();
    end

    phase = "R8 wake vs request";
    irq[0] = 1'b1; req(0, 5, 0);
    tick();
    req(1, 4, 1);
    tick();
    mon_hit[1] = 1'b1; req(1, 2, 0);
    tick();
    req(2, 3, 0);
    tick();
    pkg_irq = 1'b1; req(2, 5, 0);
    tick();

    phase = "R9 random";
    for (int k = 0; k < 2000; k++) begin
      for (int i = 0; i < N; i++) begin
        if ($urandom_range(0, 2) == 0) req(i, $urandom_range(0, 7), $urandom_range(0, 3));
        irq[i]      = $urandom_range(0, 9) == 0;
        mon_hit[i]  = $urandom_range(0, 5) == 0;
        deadline[i] = $urandom_range(0, 5) == 0;
      end
      pkg_irq = $urandom_range(0, 7) == 0;
      rst = $urandom_range(0, 99) == 0;
      tick();
    end
    rst = 1'b0;

    phase = "R1 mid-run reset";
    req(0, 5, 0); req(1, 5, 0); req(2, 5, 0); req(3, 5, 0);
    tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule